// File: doc/BRIEF.md
# Single-Thread Reorder Window with Throttled Squash

This block keeps the in-flight instructions of one hardware thread in program order. Each slot of a circular store holds a sequence number, a commit-ready flag and a squashed flag. New instructions enter at the young end through a valid/ready stream. Execution completion sets the commit-ready flag of a slot by index. The oldest instruction leaves through a valid/ready retire stream once its flag is set.

A squash request carries a boundary sequence number. Every held entry whose number is strictly greater than the boundary is marked squashed and commit-ready, so it drains out through normal retirement instead of being deleted. The marking walks from the youngest entry toward the oldest and covers at most `SQUASH_WIDTH` entries per clock, so a deep squash takes several cycles. While the walk runs, `sq_busy` is high and `sq_done` is low.

Back-pressure rules:
- The insert stream accepts only while the store is not full, no walk is running and no squash is being requested in the same cycle.
- The retire stream offers the head only when the head is ready. `retire_ack` without `head_ready` has no effect.

Top module: `rob_thread_window`

## Requirements
- R1: An insert is accepted (`ins_valid && ins_ready`) only when fewer than `DEPTH` entries are held. The accepted entry becomes the youngest entry (`tail_seq`). If the store was empty, it also becomes the head (`head_seq`). Each accepted insert raises `count` by one. `alloc_idx` gives the slot index that the next accepted insert takes.
- R2: A `cmpl_valid` pulse sets the commit-ready flag of slot `cmpl_idx`. `head_ready` is high only when at least one entry is held and the oldest entry's flag is set. Flags set on younger entries do not make the head ready.
- R3: When `head_ready && retire_ack`, the oldest entry is removed and `count` falls by one. `retire_ack` with `head_ready` low changes nothing.
- R4: A squash request while the store is empty has no effect. `sq_busy` stays 0, `sq_done` stays 1 and `count` is unchanged.
- R5: A squash request on a non-empty store marks the youngest entries in the same clock. Marking continues over later cycles, at most `SQUASH_WIDTH` entries per cycle, for as long as the entry under the walk pointer has a sequence number strictly greater than the boundary.
- R6: Marked entries stay in the store. Each one gets both the squashed flag and the commit-ready flag, and it later retires in order with `head_squashed` = 1. Entries at or below the boundary keep both flags as they were.
- R7: When the walk marks the oldest held entry, the squash is complete at that clock edge.
- R8: The walk also completes at the end of a cycle in which the pointer stops on an entry whose number is less than or equal to the boundary. If the youngest entry is already at or below the boundary, `sq_busy` never rises.
- R9: `ins_ready` is low while `sq_req` is high and while `sq_busy` is high. A squash request takes priority over an insert in the same cycle.
- R10: While a walk runs, a head entry whose number is above the boundary is not offered for retirement (`head_ready` = 0), even if its commit-ready flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert can be accepted |
| ins_seq | input | SEQ_W | Sequence number of inserted instruction |
| alloc_idx | output | IDX_W | Slot index the next accepted insert takes |
| cmpl_valid | input | 1 | Completion pulse |
| cmpl_idx | input | IDX_W | Slot whose commit-ready flag is set |
| head_ready | output | 1 | Oldest entry offered for retirement |
| retire_ack | input | 1 | Retire the offered head |
| head_seq | output | SEQ_W | Sequence number of oldest entry (0 when empty) |
| head_squashed | output | 1 | Squashed flag of oldest entry |
| tail_seq | output | SEQ_W | Sequence number of youngest entry (0 when empty) |
| sq_req | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary sequence number |
| sq_busy | output | 1 | Squash walk in progress |
| sq_done | output | 1 | No squash walk pending |
| count | output | IDX_W+1 | Number of held entries |

## Verification
The hardest case to reach from the ports is a walk that spans several cycles while the head entry is already commit-ready. In that state the only thing holding back retirement is the boundary check on the head. The bench builds it by completing every held entry first, then issuing a squash whose boundary lies below the oldest number. The walk therefore needs more than one cycle before it reaches the head. The bench then samples `head_ready` during the busy cycle and again after completion. Walk length is measured by counting busy cycles for boundaries that stop mid-store, reach the head, or stop before marking anything.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_WALK = 1'b1
  } sq_state_e;
endpackage

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic [CNT_W-1:0] occupancy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_idx  <= '0;
      next_idx  <= '0;
      occupancy <= '0;
    end else begin
      if (push) next_idx <= next_idx + IDX_W'(1);
      if (pop)  head_idx <= head_idx + IDX_W'(1);
      occupancy <= occupancy + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/rob_squash_walker.sv
module rob_squash_walker #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int WIDTH = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        active,
  input  logic                        fresh,
  input  logic [IDX_W-1:0]            start_ptr,
  input  logic [IDX_W-1:0]            head_idx,
  input  logic [SEQ_W-1:0]            limit,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_tab,
  output logic [DEPTH-1:0]            mark,
  output logic [IDX_W-1:0]            end_ptr,
  output logic                        finish
);
  logic [IDX_W-1:0] p;
  logic             halt;

  always_comb begin
    mark   = '0;
    p      = start_ptr;
    finish = 1'b0;
    halt   = 1'b0;
    if (active) begin
      // A resumed walk whose pointer already sits below the boundary ends at once.
      if (!fresh && (seq_tab[p] < limit)) begin
        finish = 1'b1;
      end else begin
        for (int k = 0; k < WIDTH; k++) begin
          if (!halt) begin
            if (seq_tab[p] > limit) begin
              mark[p] = 1'b1;
              if (p == head_idx) begin
                finish = 1'b1;
                halt   = 1'b1;
              end else begin
                p = p - IDX_W'(1);
              end
            end else begin
              halt = 1'b1;
            end
          end
        end
        if (!finish && (seq_tab[p] <= limit)) finish = 1'b1;
      end
    end
    end_ptr = p;
  end
endmodule

// File: rtl/rob_thread_window.sv
module rob_thread_window #(
  parameter int DEPTH        = 8,
  parameter int SEQ_W        = 16,
  parameter int SQUASH_WIDTH = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SEQ_W-1:0] ins_seq,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             cmpl_valid,
  input  logic [IDX_W-1:0] cmpl_idx,
  output logic             head_ready,
  input  logic             retire_ack,
  output logic [SEQ_W-1:0] head_seq,
  output logic             head_squashed,
  output logic [SEQ_W-1:0] tail_seq,
  input  logic             sq_req,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             sq_busy,
  output logic             sq_done,
  output logic [CNT_W-1:0] count
);
  import rob_pkg::*;

  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0]            rdy_q;
  logic [DEPTH-1:0]            sqd_q;
  sq_state_e                   state_q;
  logic [IDX_W-1:0]            walk_ptr_q;
  logic [SEQ_W-1:0]            lim_q;

  logic [IDX_W-1:0] head_idx, next_idx, youngest;
  logic             ins_fire, ret_fire, nonempty, busy;
  logic             walk_active, walk_fresh, walk_finish, head_blocked;
  logic [IDX_W-1:0] walk_start, walk_end;
  logic [SEQ_W-1:0] walk_limit;
  logic [DEPTH-1:0] walk_mark;

  rob_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ins_fire),
    .pop       (ret_fire),
    .head_idx  (head_idx),
    .next_idx  (next_idx),
    .occupancy (count)
  );

  assign nonempty = (count != '0);
  assign busy     = (state_q == SQ_WALK);
  assign youngest = next_idx - IDX_W'(1);

  // Insert stream: squash wins, a running walk back-pressures.
  assign ins_ready = (count != CNT_W'(DEPTH)) && !busy && !sq_req;
  assign ins_fire  = ins_valid && ins_ready;
  assign alloc_idx = next_idx;

  // Walk setup: a new non-empty request restarts from the youngest entry.
  assign walk_fresh  = sq_req && nonempty;
  assign walk_active = walk_fresh || busy;
  assign walk_start  = walk_fresh ? youngest : walk_ptr_q;
  assign walk_limit  = walk_fresh ? sq_seq : lim_q;

  rob_squash_walker #(
    .DEPTH (DEPTH),
    .SEQ_W (SEQ_W),
    .WIDTH (SQUASH_WIDTH)
  ) u_walk (
    .active    (walk_active),
    .fresh     (walk_fresh),
    .start_ptr (walk_start),
    .head_idx  (head_idx),
    .limit     (walk_limit),
    .seq_tab   (seq_q),
    .mark      (walk_mark),
    .end_ptr   (walk_end),
    .finish    (walk_finish)
  );

  // Retire stream: a head still due for squashing is held back.
  assign head_blocked  = busy && (seq_q[head_idx] > lim_q);
  assign head_ready    = nonempty && rdy_q[head_idx] && !head_blocked;
  assign ret_fire      = head_ready && retire_ack;
  assign head_seq      = nonempty ? seq_q[head_idx] : '0;
  assign head_squashed = nonempty && sqd_q[head_idx];
  assign tail_seq      = nonempty ? seq_q[youngest] : '0;
  assign sq_busy       = busy;
  assign sq_done       = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      walk_ptr_q <= '0;
      lim_q      <= '0;
    end else begin
      state_q <= (walk_active && !walk_finish) ? SQ_WALK : SQ_IDLE;
      if (walk_active) walk_ptr_q <= walk_end;
      if (walk_fresh)  lim_q      <= sq_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      rdy_q <= '0;
      sqd_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_fire && (next_idx == IDX_W'(i))) begin
          seq_q[i] <= ins_seq;
          rdy_q[i] <= 1'b0;
          sqd_q[i] <= 1'b0;
        end else begin
          if (walk_mark[i]) begin
            rdy_q[i] <= 1'b1;
            sqd_q[i] <= 1'b1;
          end
          if (cmpl_valid && (cmpl_idx == IDX_W'(i))) rdy_q[i] <= 1'b1;
        end
      end
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_head_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    head_ready |-> (count != '0));

  assert_retire_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !ins_fire) |=> (count == $past(count) - CNT_W'(1)));

  assert_empty_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req && (count == '0) && !sq_busy) |=> sq_done);

  assert_oldest_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_active && walk_mark[head_idx]) |=> !sq_busy);

  assert_no_growth_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_busy |=> (count <= $past(count)));
endmodule

// File: tb/test_rob_thread_window.sv
module test_rob_thread_window;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;
  localparam int SQW   = 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ins_valid = 1'b0;
  logic             ins_ready;
  logic [SEQ_W-1:0] ins_seq = '0;
  logic [IDX_W-1:0] alloc_idx;
  logic             cmpl_valid = 1'b0;
  logic [IDX_W-1:0] cmpl_idx = '0;
  logic             head_ready;
  logic             retire_ack = 1'b0;
  logic [SEQ_W-1:0] head_seq;
  logic             head_squashed;
  logic [SEQ_W-1:0] tail_seq;
  logic             sq_req = 1'b0;
  logic [SEQ_W-1:0] sq_seq = '0;
  logic             sq_busy;
  logic             sq_done;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int errors = 0;
  int slot = 0;

  always #10 clk = ~clk;

  rob_thread_window #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQUASH_WIDTH(SQW)) i_rob_thread_window (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_seq(ins_seq), .alloc_idx(alloc_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
    .head_ready(head_ready), .retire_ack(retire_ack),
    .head_seq(head_seq), .head_squashed(head_squashed), .tail_seq(tail_seq),
    .sq_req(sq_req), .sq_seq(sq_seq), .sq_busy(sq_busy), .sq_done(sq_done), .count(count)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input int s);
    ins_valid = 1'b1;
    ins_seq   = SEQ_W'(s);
    #1;
    check("R1", "ins_ready before push", int'(ins_ready), 1);
    check("R1", "alloc_idx", int'(alloc_idx), slot);
    step();
    ins_valid = 1'b0;
    slot = (slot + 1) % DEPTH;
  endtask

  task automatic complete(input int idx);
    cmpl_valid = 1'b1;
    cmpl_idx   = IDX_W'(idx % DEPTH);
    step();
    cmpl_valid = 1'b0;
  endtask

  task automatic retire(input string req, input int s, input int sqd);
    check(req, "head_ready before retire", int'(head_ready), 1);
    check(req, "head_seq", int'(head_seq), s);
    check(req, "head_squashed", int'(head_squashed), sqd);
    retire_ack = 1'b1;
    step();
    retire_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "count after reset", int'(count), 0);
    check("R2", "head_ready after reset", int'(head_ready), 0);
    check("R4", "sq_done after reset", int'(sq_done), 1);
    check("R9", "ins_ready after reset", int'(ins_ready), 1);
  endtask

  task automatic t_fill_retire();
    int base = slot;
    for (int i = 0; i < 4; i++) push(100 + i);
    check("R1", "count after 4 pushes", int'(count), 4);
    check("R1", "head_seq first insert", int'(head_seq), 100);
    check("R1", "tail_seq youngest", int'(tail_seq), 103);
    check("R2", "head_ready nothing done", int'(head_ready), 0);
    complete(base + 1);
    check("R2", "head_ready younger done", int'(head_ready), 0);
    complete(base);
    check("R2", "head_ready head done", int'(head_ready), 1);
    retire("R3", 100, 0);
    retire("R3", 101, 0);
    check("R3", "count after 2 retires", int'(count), 2);
    retire_ack = 1'b1;
    step();
    retire_ack = 1'b0;
    check("R3", "ack without ready keeps count", int'(count), 2);
    check("R3", "ack without ready keeps head", int'(head_seq), 102);
    complete(base + 2);
    complete(base + 3);
    retire("R3", 102, 0);
    retire("R3", 103, 0);
    check("R3", "count drained", int'(count), 0);
    check("R2", "head_ready empty", int'(head_ready), 0);
  endtask

  task automatic t_full();
    int base = slot;
    for (int i = 0; i < DEPTH; i++) push(200 + i);
    check("R1", "count full", int'(count), DEPTH);
    ins_valid = 1'b1;
    ins_seq   = 16'd300;
    #1;
    check("R1", "ins_ready when full", int'(ins_ready), 0);
    step();
    ins_valid = 1'b0;
    check("R1", "count after refused push", int'(count), DEPTH);
    check("R1", "tail after refused push", int'(tail_seq), 207);
    for (int i = 0; i < DEPTH; i++) complete(base + i);
    for (int i = 0; i < DEPTH; i++) retire("R1", 200 + i, 0);
  endtask

  task automatic t_empty_squash();
    sq_req = 1'b1;
    sq_seq = 16'd5;
    step();
    sq_req = 1'b0;
    check("R4", "busy after empty squash", int'(sq_busy), 0);
    check("R4", "done after empty squash", int'(sq_done), 1);
    check("R4", "count after empty squash", int'(count), 0);
  endtask

  task automatic t_partial_squash();
    int base = slot;
    for (int i = 0; i < 6; i++) push(10 + i);
    sq_req    = 1'b1;
    sq_seq    = 16'd11;
    ins_valid = 1'b1;
    ins_seq   = 16'd99;
    #1;
    check("R9", "ins_ready with sq_req", int'(ins_ready), 0);
    step();
    sq_req    = 1'b0;
    check("R5", "busy after first step", int'(sq_busy), 1);
    check("R5", "done after first step", int'(sq_done), 0);
    check("R9", "ins_ready while busy", int'(ins_ready), 0);
    step();
    ins_valid = 1'b0;
    check("R8", "busy after stop at boundary", int'(sq_busy), 0);
    check("R6", "count keeps squashed", int'(count), 6);
    check("R9", "tail unchanged by blocked insert", int'(tail_seq), 15);
    check("R6", "head not marked", int'(head_ready), 0);
    complete(base);
    complete(base + 1);
    retire("R6", 10, 0);
    retire("R6", 11, 0);
    for (int i = 12; i < 16; i++) retire("R6", i, 1);
  endtask

  task automatic t_full_walk();
    int busy_cycles = 0;
    for (int i = 0; i < 6; i++) push(20 + i);
    sq_req = 1'b1;
    sq_seq = 16'd19;
    step();
    sq_req = 1'b0;
    for (int i = 0; i < 6 && sq_busy; i++) begin
      busy_cycles++;
      step();
    end
    check("R5", "busy cycles for 6 entries", busy_cycles, 2);
    check("R7", "done after reaching oldest", int'(sq_done), 1);
    for (int i = 0; i < 6; i++) retire("R7", 20 + i, 1);
  endtask

  task automatic t_head_block();
    int base = slot;
    for (int i = 0; i < 4; i++) push(30 + i);
    for (int i = 0; i < 4; i++) complete(base + i);
    check("R10", "head_ready before squash", int'(head_ready), 1);
    sq_req = 1'b1;
    sq_seq = 16'd29;
    step();
    sq_req = 1'b0;
    check("R10", "busy mid walk", int'(sq_busy), 1);
    check("R10", "head held during walk", int'(head_ready), 0);
    step();
    check("R7", "done at head", int'(sq_done), 1);
    for (int i = 0; i < 4; i++) retire("R10", 30 + i, 1);
  endtask

  task automatic t_noop_squash();
    int base = slot;
    push(40);
    push(41);
    sq_req = 1'b1;
    sq_seq = 16'd50;
    step();
    sq_req = 1'b0;
    check("R8", "busy never rises", int'(sq_busy), 0);
    check("R8", "nothing marked", int'(head_ready), 0);
    complete(base);
    complete(base + 1);
    retire("R8", 40, 0);
    retire("R8", 41, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_fill_retire();
    t_full();
    t_empty_squash();
    t_partial_squash();
    t_full_walk();
    t_head_block();
    t_noop_squash();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule